// File: doc/BRIEF.md
# Generalized Parallel Counter

This block is a combinational generalized parallel counter. It takes a set of input bits that belong to one or two adjacent bit columns. It returns the binary value of the set bits, with each bit counted at the weight of its column. Compressor trees use it in place of plain full adders. One counter takes in a whole column of partial-product or operand bits, or a column plus its neighbour, and hands a short binary number to the next stage.

Two parameters set the number of weight-one bits and weight-two bits, and the output width follows from them. If only one column is used and it holds four to six bits, the counter is built like a carry-chain counter. A full adder and a half adder compress the upper bits. A two-bit ripple adder then merges their sum bits and their carry bits, and the lowest input bit is its carry-in. Any other mix of columns uses a weighted sum.

A separate boundary cell is provided for placing counters next to each other on one shared carry chain. It adds its isolation bit to itself, together with the incoming carry. As a result, the carry from the lower counter comes out unchanged on the sum, and the isolation bit goes on as the next counter's carry-in.

Top module: `gpc_unit`

## Requirements
- R1: With K0=6 and K1=0, `count` (3 bits) equals the number of ones in `in_bits[5:0]` for every one of the 64 input patterns.
- R2: With K0=5 and K1=0, `count` (3 bits) equals the number of ones in `in_bits[4:0]` for all 32 patterns.
- R3: With K0=4 and K1=3, `in_bits[3:0]` carry weight one and `in_bits[6:4]` carry weight two, and `count` (4 bits) equals the weight-one ones plus twice the weight-two ones for all 128 patterns.
- R4: With K0=5 and K1=3, `in_bits[4:0]` carry weight one and `in_bits[7:5]` carry weight two, and `count` (4 bits) equals the weighted sum for all 256 patterns.
- R5: `count` is ceil(log2(K0+2*K1+1)) bits wide, never exceeds K0+2*K1, and reaches exactly K0+2*K1 when all inputs are one.
- R6: `count[0]` equals the XOR of the weight-one bits `in_bits[K0-1:0]`.
- R7: In the single-column chain form, `in_bits[0]` acts as a carry-in: with the other bits held, setting it raises `count` by exactly one.
- R8: The boundary sum `bnd_sum` always equals `bnd_carry_in`, whatever `bnd_bit` is.
- R9: The boundary carry-out `bnd_carry_out` always equals `bnd_bit`, whatever `bnd_carry_in` is.
- R10: All-zero inputs give a zero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_bits | input | K0+K1 | Counted bits: low K0 at weight one, upper K1 at weight two |
| count | output | NW | Weighted count, NW = ceil(log2(K0+2*K1+1)) |
| bnd_carry_in | input | 1 | Carry arriving at the boundary cell from the lower counter |
| bnd_bit | input | 1 | Isolation bit fed to both operands of the boundary cell |
| bnd_sum | output | 1 | Boundary cell sum, the lower counter's carry passed through |
| bnd_carry_out | output | 1 | Boundary cell carry, the next counter's carry-in |

## Verification
Each of the four column mixes is driven through every input pattern, and the result is compared with a weighted popcount. This separates weight-one from weight-two placement and exposes any lost carry in the ripple stage. Pairs of patterns that differ only in the lowest bit single out the carry-in path. The all-ones and all-zero patterns pin the range limits. Random values for the boundary cell, together with its four exhaustive combinations, confirm that the carry passes through the sum and the isolation bit comes out as carry, with no crosstalk between the two.

// File: rtl/gpc_unit.sv
module gpc_unit #(
  parameter int K0 = 6,
  parameter int K1 = 0,
  localparam int NI = K0 + K1,
  localparam int NW = $clog2(K0 + 2 * K1 + 1)
) (
  input  logic [NI-1:0] in_bits,
  output logic [NW-1:0] count,
  input  logic          bnd_carry_in,
  input  logic          bnd_bit,
  output logic          bnd_sum,
  output logic          bnd_carry_out
);

  generate
    if (K1 == 0 && K0 >= 4 && K0 <= 6) begin : g_chain
      logic [5:0] p;
      logic s0, c0, s1, c1, k0;
      assign p  = 6'(in_bits);
      assign s0 = p[1] ^ p[2] ^ p[3];
      assign c0 = (p[1] & p[2]) | (p[3] & (p[1] ^ p[2]));
      assign s1 = p[4] ^ p[5];
      assign c1 = p[4] & p[5];
      assign k0 = (s0 & s1) | (p[0] & (s0 ^ s1));
      assign count = NW'({(c0 & c1) | (k0 & (c0 ^ c1)), c0 ^ c1 ^ k0, s0 ^ s1 ^ p[0]});
    end else begin : g_sum
      always_comb begin
        count = '0;
        for (int i = 0; i < NI; i++)
          if (in_bits[i]) count = count + ((i < K0) ? NW'(1) : NW'(2));
      end
    end
  endgenerate

  assign {bnd_carry_out, bnd_sum} = 2'(bnd_bit) + 2'(bnd_bit) + 2'(bnd_carry_in);

endmodule

// File: rtl/gpc_unit_chk.sv
module gpc_unit_chk #(
  parameter int K0 = 6,
  parameter int K1 = 0,
  localparam int NI = K0 + K1,
  localparam int NW = $clog2(K0 + 2 * K1 + 1)
) (
  input logic [NI-1:0] in_bits,
  input logic [NW-1:0] count,
  input logic          bnd_carry_in,
  input logic          bnd_bit,
  input logic          bnd_sum,
  input logic          bnd_carry_out
);
  always_comb begin
    if (!$isunknown(in_bits)) begin
      assert_no_overflow_R5: assert (int'(count) <= K0 + 2 * K1);
      assert_parity_R6: assert (count[0] == ^in_bits[K0-1:0]);
      if (in_bits == '0) assert_zero_R10: assert (count == '0);
    end
    if (!$isunknown({bnd_carry_in, bnd_bit})) begin
      assert_pass_carry_R8: assert (bnd_sum == bnd_carry_in);
      assert_isolate_R9: assert (bnd_carry_out == bnd_bit);
    end
  end
endmodule

bind gpc_unit gpc_unit_chk #(.K0(K0), .K1(K1)) u_chk (
  .in_bits(in_bits), .count(count), .bnd_carry_in(bnd_carry_in),
  .bnd_bit(bnd_bit), .bnd_sum(bnd_sum), .bnd_carry_out(bnd_carry_out)
);

// File: tb/tb_gpc_unit.sv
module tb_gpc_unit;
  logic clk = 0;
  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  logic [5:0] i6;  logic [2:0] c6;
  logic [4:0] i5;  logic [2:0] c5;
  logic [6:0] i34; logic [3:0] c34;
  logic [7:0] i35; logic [3:0] c35;
  logic bci, bb;
  logic bs6, bo6, bs5, bo5, bs34, bo34, bs35, bo35;

  gpc_unit #(.K0(6), .K1(0)) dut (.in_bits(i6), .count(c6), .bnd_carry_in(bci),
    .bnd_bit(bb), .bnd_sum(bs6), .bnd_carry_out(bo6));
  gpc_unit #(.K0(5), .K1(0)) dut5 (.in_bits(i5), .count(c5), .bnd_carry_in(bci),
    .bnd_bit(bb), .bnd_sum(bs5), .bnd_carry_out(bo5));
  gpc_unit #(.K0(4), .K1(3)) dut34 (.in_bits(i34), .count(c34), .bnd_carry_in(bci),
    .bnd_bit(bb), .bnd_sum(bs34), .bnd_carry_out(bo34));
  gpc_unit #(.K0(5), .K1(3)) dut35 (.in_bits(i35), .count(c35), .bnd_carry_in(bci),
    .bnd_bit(bb), .bnd_sum(bs35), .bnd_carry_out(bo35));

  function automatic int wsum(int k0, int k1, int v);
    int s = 0;
    for (int i = 0; i < k0 + k1; i++) if ((v >> i) & 1) s += (i < k0) ? 1 : 2;
    return s;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_bnd();
    chk("R8 bnd_sum", int'(bs6), int'(bci));
    chk("R9 bnd_carry_out", int'(bo6), int'(bb));
    chk("R8 bnd_sum k34", int'(bs34), int'(bci));
    chk("R9 bnd_carry_out k35", int'(bo35), int'(bb));
  endtask

  initial begin
    int prev;
    process::self().srandom(11);
    i6 = '0; i5 = '0; i34 = '0; i35 = '0; bci = 0; bb = 0;
    @(negedge clk);
    chk("R10 zero k6", int'(c6), 0);
    chk("R10 zero k5", int'(c5), 0);
    chk("R10 zero k34", int'(c34), 0);
    chk("R10 zero k35", int'(c35), 0);

    for (int v = 0; v < 256; v++) begin
      @(posedge clk);
      i6 = 6'(v); i5 = 5'(v); i34 = 7'(v); i35 = 8'(v);
      @(negedge clk);
      if (v < 64)  chk("R1 six-input count", int'(c6), wsum(6, 0, v));
      if (v < 32)  chk("R2 five-input count", int'(c5), wsum(5, 0, v));
      if (v < 128) chk("R3 mixed 3,4 count", int'(c34), wsum(4, 3, v));
      chk("R4 mixed 3,5 count", int'(c35), wsum(5, 3, v));
      chk("R6 lsb parity", int'(c35[0]), wsum(5, 0, v & 31) & 1);
    end

    @(posedge clk); i6 = '1; i5 = '1; i34 = '1; i35 = '1;
    @(negedge clk);
    chk("R5 max k6", int'(c6), 6);
    chk("R5 max k5", int'(c5), 5);
    chk("R5 max k34", int'(c34), 10);
    chk("R5 max k35", int'(c35), 11);
    chk("R5 width k34", $bits(c34), 4);

    for (int n = 0; n < 40; n++) begin
      int r = int'($urandom_range(0, 31));
      @(posedge clk); i6 = 6'(r << 1);
      @(negedge clk); prev = int'(c6);
      @(posedge clk); i6 = 6'((r << 1) | 1);
      @(negedge clk); chk("R7 carry-in step", int'(c6), prev + 1);
    end

    for (int v = 0; v < 4; v++) begin
      @(posedge clk); bci = v[0]; bb = v[1];
      @(negedge clk); chk_bnd();
    end
    for (int n = 0; n < 50; n++) begin
      @(posedge clk);
      bci = 1'($urandom); bb = 1'($urandom); i6 = 6'($urandom);
      @(negedge clk);
      chk_bnd();
      chk("R1 random count", int'(c6), wsum(6, 0, int'(i6)));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule